// File: doc/BRIEF.md
# Multi-Port Interleaved Memory Address Decoder

This block sits in front of one word-addressed memory module that is shared by four requester ports. Every port has a private configuration: an enable, a module number, a capacity of 32K or 64K words, an interleave mode and an address-form choice of 18 or 22 significant bits. When a port presents a word address, the block decides whether that address belongs to this module and forms the word index inside the module. One clock later it returns a registered hit flag and index for that port.

Interleaving spreads consecutive addresses across two or four modules. The lowest address bits take over the role of the module-number bits that sit just above the in-module range. Which positions they displace depends on the capacity. The displaced bits become the lowest bits of the index, so each interleaved module still sees a contiguous index range.

Address bits are written a[k] with k = 0 as the least significant bit. The address port is 24 bits wide. The module number formed from the address is zero-extended before it is compared with the 7-bit configured base.

Top module: `imem_port_decoder`

## Requirements
- R1: The four ports decode at the same time and independently. Each port uses only its own configuration and its own address.
- R2: A port whose captured enable is 0 never reports a hit.
- R3: rsp_valid for a port is its req_valid delayed by one clock. rsp_hit is 1 only together with rsp_valid. rsp_index is updated on each request and holds its value in cycles without a request.
- R4: Interleave code 00 with 32K (size bit 0): the module number is a[23:15] and the index is {0, a[14:0]}.
- R5: Interleave code 00 with 64K (size bit 1): the module number is a[23:16] and the index is a[15:0].
- R6: Code 01 (2-way) with 32K: the module number is {a[23:16], a[0]} and the index is {0, a[14:1], a[15]}.
- R7: Code 01 with 64K: the module number is {a[23:17], a[0]} and the index is {a[15:1], a[16]}.
- R8: Code 10 (4-way) with 32K: the module number is {a[23:17], a[1:0]} and the index is {0, a[14:2], a[16:15]}.
- R9: Code 10 with 64K: the module number is {a[23:18], a[1:0]} and the index is {a[15:2], a[17:16]}.
- R10: With the wide-form bit 1, any set bit in a[23:22] gives no hit. With the wide-form bit 0, any set bit in a[23:18] gives no hit.
- R11: A port's configuration is captured only on a clock edge where that port has no request. It governs the requests that follow. Changes made while a request is held are ignored until the port goes idle for a cycle.
- R12: The reserved interleave code 11 never produces a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en_i | input | 4 | Per-port enable |
| cfg_base_i | input | 28 | Per-port 7-bit module number, port p at [7p+6:7p] |
| cfg_size64_i | input | 4 | Per-port capacity: 1 = 64K words, 0 = 32K words |
| cfg_ilv_i | input | 8 | Per-port interleave code at [2p+1:2p]: 00 none, 01 2-way, 10 4-way, 11 reserved |
| cfg_wide_i | input | 4 | Per-port address form: 1 = 22-bit, 0 = 18-bit |
| req_valid_i | input | 4 | Per-port request strobe |
| req_addr_i | input | 96 | Per-port 24-bit word address, port p at [24p+23:24p] |
| rsp_valid_o | output | 4 | Registered request strobe |
| rsp_hit_o | output | 4 | Registered hit flag |
| rsp_index_o | output | 64 | Registered 16-bit word index, port p at [16p+15:16p] |

## Verification
Each capacity and interleave combination is tried with one address built to hit. The same address is then applied with each of its 24 bits flipped in turn. A flip inside the index field must keep the hit and move exactly the expected index bit, while a flip in a module-number or out-of-range position must drop the hit. This pattern separates a wrong swap position from a wrong index rotation. One address is driven on all four ports at once, each port set to a different mode, which shows whether configuration or state leaks between ports. Separate patterns cover the remaining controls:
- an address that matches only because a bit above the 18-bit range is set, applied under both address forms;
- a change of base made while a request is held;
- the reserved interleave code;
- a disabled port that would otherwise match.

// File: rtl/idec_pkg.sv
`timescale 1ns/1ps
package idec_pkg;

    typedef enum logic [1:0] {
        ILV_NONE = 2'b00,
        ILV_TWO  = 2'b01,
        ILV_FOUR = 2'b10,
        ILV_RSVD = 2'b11
    } ilv_mode_e;

    // number of low address bits that steer module selection
    function automatic int ilv_sel_bits(ilv_mode_e mode);
        case (mode)
            ILV_TWO:  return 1;
            ILV_FOUR: return 2;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/idec_ilv_swap.sv
`timescale 1ns/1ps
module idec_ilv_swap
    import idec_pkg::*;
#(
    parameter int IN_W       = 24,
    parameter int SMALL_BITS = 15,
    parameter int MAX_SEL    = 2
) (
    input  logic [IN_W-1:0] addr_i,
    input  logic            size64_i,
    input  ilv_mode_e       mode_i,
    output logic [IN_W-1:0] addr_o
);

    // Exchange the lowest address bits with the bits just above the
    // in-module range. The lowest bits then act as module-number bits,
    // and the displaced bits land at the bottom of the index.
    always_comb begin
        int lo;
        int nsel;
        lo     = SMALL_BITS + (size64_i ? 1 : 0);
        nsel   = ilv_sel_bits(mode_i);
        addr_o = addr_i;
        for (int b = 0; b < MAX_SEL; b++) begin
            if (b < nsel) begin
                addr_o[b]      = addr_i[lo + b];
                addr_o[lo + b] = addr_i[b];
            end
        end
    end

endmodule

// File: rtl/idec_port_match.sv
`timescale 1ns/1ps
module idec_port_match
    import idec_pkg::*;
#(
    parameter int IN_W       = 24,
    parameter int WIDE_W     = 22,
    parameter int NARROW_W   = 18,
    parameter int SMALL_BITS = 15,
    parameter int BASE_W     = WIDE_W - SMALL_BITS,
    parameter int IDX_W      = SMALL_BITS + 1
) (
    input  logic [IN_W-1:0]   raw_i,
    input  logic [IN_W-1:0]   swp_i,
    input  logic              en_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              size64_i,
    input  ilv_mode_e         mode_i,
    input  logic              wide_i,
    output logic              match_o,
    output logic [IDX_W-1:0]  index_o
);

    logic [IN_W-1:0] above;
    logic [IN_W-1:0] sel;
    logic            in_range;
    logic            base_eq;

    always_comb begin
        // bits above the chosen address form must all be clear
        above    = wide_i ? (raw_i >> WIDE_W) : (raw_i >> NARROW_W);
        in_range = (above == '0);
        // module number: everything above the in-module range
        sel      = swp_i >> (SMALL_BITS + (size64_i ? 1 : 0));
        base_eq  = (sel == IN_W'(base_i));
        match_o  = en_i && in_range && base_eq && (mode_i != ILV_RSVD);
        index_o  = swp_i[IDX_W-1:0];
        if (!size64_i) begin
            index_o[IDX_W-1] = 1'b0;
        end
    end

endmodule

// File: rtl/imem_port_decoder.sv
`timescale 1ns/1ps
module imem_port_decoder
    import idec_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int IN_W       = 24,
    parameter int WIDE_W     = 22,
    parameter int NARROW_W   = 18,
    parameter int SMALL_BITS = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS-1:0]        cfg_en_i,
    input  logic [NPORTS*(WIDE_W-SMALL_BITS)-1:0] cfg_base_i,
    input  logic [NPORTS-1:0]        cfg_size64_i,
    input  logic [NPORTS*2-1:0]      cfg_ilv_i,
    input  logic [NPORTS-1:0]        cfg_wide_i,
    input  logic [NPORTS-1:0]        req_valid_i,
    input  logic [NPORTS*IN_W-1:0]   req_addr_i,
    output logic [NPORTS-1:0]        rsp_valid_o,
    output logic [NPORTS-1:0]        rsp_hit_o,
    output logic [NPORTS*(SMALL_BITS+1)-1:0] rsp_index_o
);

    localparam int BASE_W = WIDE_W - SMALL_BITS;
    localparam int IDX_W  = SMALL_BITS + 1;

    typedef struct packed {
        logic              en;
        logic [BASE_W-1:0] base;
        logic              size64;
        ilv_mode_e         ilv;
        logic              wide;
    } pcfg_t;

    typedef struct packed {
        pcfg_t [NPORTS-1:0]             cfg;
        logic  [NPORTS-1:0]             vld;
        logic  [NPORTS-1:0]             hit;
        logic  [NPORTS-1:0][IDX_W-1:0]  idx;
    } state_t;

    state_t st_d, st_q;

    logic [NPORTS-1:0]            match_w;
    logic [NPORTS-1:0][IDX_W-1:0] idx_w;
    logic [NPORTS-1:0][IN_W-1:0]  swp_w;

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            idec_ilv_swap #(
                .IN_W       (IN_W),
                .SMALL_BITS (SMALL_BITS),
                .MAX_SEL    (2)
            ) u_swap (
                .addr_i   (req_addr_i[p*IN_W +: IN_W]),
                .size64_i (st_q.cfg[p].size64),
                .mode_i   (st_q.cfg[p].ilv),
                .addr_o   (swp_w[p])
            );

            idec_port_match #(
                .IN_W       (IN_W),
                .WIDE_W     (WIDE_W),
                .NARROW_W   (NARROW_W),
                .SMALL_BITS (SMALL_BITS),
                .BASE_W     (BASE_W),
                .IDX_W      (IDX_W)
            ) u_match (
                .raw_i    (req_addr_i[p*IN_W +: IN_W]),
                .swp_i    (swp_w[p]),
                .en_i     (st_q.cfg[p].en),
                .base_i   (st_q.cfg[p].base),
                .size64_i (st_q.cfg[p].size64),
                .mode_i   (st_q.cfg[p].ilv),
                .wide_i   (st_q.cfg[p].wide),
                .match_o  (match_w[p]),
                .index_o  (idx_w[p])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NPORTS; p++) begin
            // configuration is only captured while the port is idle
            if (!req_valid_i[p]) begin
                st_d.cfg[p].en     = cfg_en_i[p];
                st_d.cfg[p].base   = cfg_base_i[p*BASE_W +: BASE_W];
                st_d.cfg[p].size64 = cfg_size64_i[p];
                st_d.cfg[p].ilv    = ilv_mode_e'(cfg_ilv_i[p*2 +: 2]);
                st_d.cfg[p].wide   = cfg_wide_i[p];
            end
            st_d.vld[p] = req_valid_i[p];
            st_d.hit[p] = req_valid_i[p] && match_w[p];
            if (req_valid_i[p]) begin
                st_d.idx[p] = idx_w[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rsp_valid_o = st_q.vld;
        rsp_hit_o   = st_q.hit;
        for (int p = 0; p < NPORTS; p++) begin
            rsp_index_o[p*IDX_W +: IDX_W] = st_q.idx[p];
        end
    end

endmodule

// File: rtl/idec_chk.sv
`timescale 1ns/1ps
module idec_chk #(
    parameter int NPORTS     = 4,
    parameter int IN_W       = 24,
    parameter int WIDE_W     = 22,
    parameter int SMALL_BITS = 15
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NPORTS-1:0]               cfg_en_i,
    input logic [NPORTS*2-1:0]             cfg_ilv_i,
    input logic [NPORTS-1:0]               req_valid_i,
    input logic [NPORTS*IN_W-1:0]          req_addr_i,
    input logic [NPORTS-1:0]               rsp_valid_o,
    input logic [NPORTS-1:0]               rsp_hit_o,
    input logic [NPORTS*(SMALL_BITS+1)-1:0] rsp_index_o
);

    localparam int IDX_W = SMALL_BITS + 1;

    // cycles since reset release, saturating
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_chk
            assert_rsp_tracks_req_R3: assert property (@(posedge clk)
                disable iff (!rst_n || age_q == 2'd0)
                rsp_valid_o[p] == $past(req_valid_i[p]));

            assert_hit_needs_valid_R3: assert property (@(posedge clk)
                disable iff (!rst_n)
                rsp_hit_o[p] |-> rsp_valid_o[p]);

            assert_index_holds_R3: assert property (@(posedge clk)
                disable iff (!rst_n || age_q == 2'd0)
                !$past(req_valid_i[p]) |-> $stable(rsp_index_o[p*IDX_W +: IDX_W]));

            assert_disabled_silent_R2: assert property (@(posedge clk)
                disable iff (!rst_n || age_q < 2'd2)
                (rsp_hit_o[p] && !$past(req_valid_i[p], 2)) |-> $past(cfg_en_i[p], 2));

            assert_rsvd_silent_R12: assert property (@(posedge clk)
                disable iff (!rst_n || age_q < 2'd2)
                (rsp_hit_o[p] && !$past(req_valid_i[p], 2)) |-> ($past(cfg_ilv_i[p*2 +: 2], 2) != 2'b11));

            assert_range_limit_R10: assert property (@(posedge clk)
                disable iff (!rst_n || age_q == 2'd0)
                rsp_hit_o[p] |-> (($past(req_addr_i[p*IN_W +: IN_W]) >> WIDE_W) == '0));
        end
    endgenerate

endmodule

bind imem_port_decoder idec_chk #(
    .NPORTS     (NPORTS),
    .IN_W       (IN_W),
    .WIDE_W     (WIDE_W),
    .SMALL_BITS (SMALL_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en_i    (cfg_en_i),
    .cfg_ilv_i   (cfg_ilv_i),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_index_o (rsp_index_o)
);

// File: tb/imem_port_decoder_tb.sv
`timescale 1ns/1ps
module imem_port_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_en = '0;
    logic [27:0] cfg_base = '0;
    logic [3:0]  cfg_size64 = '0;
    logic [7:0]  cfg_ilv = '0;
    logic [3:0]  cfg_wide = '0;
    logic [3:0]  req_valid = '0;
    logic [95:0] req_addr = '0;
    logic [3:0]  rsp_valid;
    logic [3:0]  rsp_hit;
    logic [63:0] rsp_index;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    // configuration the bench believes is in effect
    logic       e_en [4];
    logic [6:0] e_base [4];
    logic       e_s64 [4];
    logic [1:0] e_ilv [4];
    logic       e_wide [4];

    always #2.5 clk = ~clk;

    imem_port_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_en_i     (cfg_en),
        .cfg_base_i   (cfg_base),
        .cfg_size64_i (cfg_size64),
        .cfg_ilv_i    (cfg_ilv),
        .cfg_wide_i   (cfg_wide),
        .req_valid_i  (req_valid),
        .req_addr_i   (req_addr),
        .rsp_valid_o  (rsp_valid),
        .rsp_hit_o    (rsp_hit),
        .rsp_index_o  (rsp_index)
    );

    function automatic void model(input int p, input logic [23:0] a,
                                  output logic h, output logic [15:0] ix);
        logic [23:0] sel;
        logic        rng;
        rng = e_wide[p] ? (a[23:22] == 2'b0) : (a[23:18] == 6'b0);
        case (e_ilv[p])
            2'b00: if (e_s64[p]) begin sel = 24'(a[23:16]); ix = a[15:0]; end
                   else begin sel = 24'(a[23:15]); ix = {1'b0, a[14:0]}; end
            2'b01: if (e_s64[p]) begin sel = 24'({a[23:17], a[0]}); ix = {a[15:1], a[16]}; end
                   else begin sel = 24'({a[23:16], a[0]}); ix = {1'b0, a[14:1], a[15]}; end
            2'b10: if (e_s64[p]) begin sel = 24'({a[23:18], a[1:0]}); ix = {a[15:2], a[17:16]}; end
                   else begin sel = 24'({a[23:17], a[1:0]}); ix = {1'b0, a[14:2], a[16:15]}; end
            default: begin sel = '1; ix = '0; end
        endcase
        h = e_en[p] && rng && (e_ilv[p] != 2'b11) && (sel == 24'(e_base[p]));
    endfunction

    task automatic chk(input string req, input int p, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s port %0d: actual %h expected %h", req, p, act, exp);
        end
    endtask

    task automatic set_port(input int p, input logic en, input logic [6:0] base,
                            input logic s64, input logic [1:0] ilv, input logic wide);
        cfg_en[p] = en;
        cfg_base[p*7 +: 7] = base;
        cfg_size64[p] = s64;
        cfg_ilv[p*2 +: 2] = ilv;
        cfg_wide[p] = wide;
        @(negedge clk);
        e_en[p] = en; e_base[p] = base; e_s64[p] = s64; e_ilv[p] = ilv; e_wide[p] = wide;
    endtask

    // compare one port's response with the model
    task automatic cmp(input string req, input int p, input logic [23:0] a);
        logic h;
        logic [15:0] ix;
        model(p, a, h, ix);
        chk({req, " valid"}, p, 16'(rsp_valid[p]), 16'd1);
        chk({req, " hit"}, p, 16'(rsp_hit[p]), 16'(h));
        if (e_ilv[p] != 2'b11) chk({req, " index"}, p, rsp_index[p*16 +: 16], ix);
    endtask

    task automatic run_vec(input int p, input logic [23:0] a, input string req);
        req_valid[p] = 1'b1;
        req_addr[p*24 +: 24] = a;
        @(negedge clk);
        req_valid[p] = 1'b0;
        cmp(req, p, a);
    endtask

    task automatic sweep(input int p, input logic [23:0] a, input string req);
        run_vec(p, a, req);
        for (int k = 0; k < 24; k++) run_vec(p, a ^ (24'd1 << k), req);
    endtask

    task automatic t_reset();
        chk("R3 reset valid", 0, 16'(rsp_valid), 16'd0);
        chk("R3 reset hit", 0, 16'(rsp_hit), 16'd0);
        chk("R3 reset index", 0, rsp_index[15:0], 16'd0);
    endtask

    task automatic t_none32();   // R4
        set_port(0, 1, 7'h2B, 0, 2'b00, 1);
        sweep(0, (24'h2B << 15) | 24'h1234, "R4");
    endtask

    task automatic t_none64();   // R5
        set_port(0, 1, 7'h15, 1, 2'b00, 1);
        sweep(0, (24'h15 << 16) | 24'hABCD, "R5");
    endtask

    task automatic t_two32();    // R6
        set_port(1, 1, 7'h2B, 0, 2'b01, 1);
        sweep(1, (24'h15 << 16) | 24'h1 | 24'h5A52, "R6");
    endtask

    task automatic t_two64();    // R7
        set_port(1, 1, 7'h15, 1, 2'b01, 1);
        sweep(1, (24'hA << 17) | 24'h1 | 24'h1B5A4, "R7");
    endtask

    task automatic t_four32();   // R8
        set_port(2, 1, 7'h2B, 0, 2'b10, 1);
        sweep(2, (24'hA << 17) | 24'h3 | 24'h1A5A4, "R8");
    endtask

    task automatic t_four64();   // R9
        set_port(3, 1, 7'h16, 1, 2'b10, 1);
        sweep(3, (24'h5 << 18) | 24'h2 | 24'h2C5A8, "R9");
    endtask

    task automatic t_ports();    // R1
        logic [23:0] av [3];
        av[0] = (24'h9 << 15) | 24'h0101;
        av[1] = (24'h4 << 16) | 24'h1;
        av[2] = 24'h02_4003;
        set_port(0, 1, 7'h09, 0, 2'b00, 1);
        set_port(1, 1, 7'h09, 0, 2'b01, 1);
        set_port(2, 1, 7'h13, 1, 2'b10, 0);
        set_port(3, 1, 7'h04, 1, 2'b00, 1);
        for (int i = 0; i < 3; i++) begin
            req_valid = 4'hF;
            req_addr = {av[i], av[i], av[i], av[i]};
            @(negedge clk);
            req_valid = '0;
            for (int p = 0; p < 4; p++) cmp("R1", p, av[i]);
        end
    endtask

    task automatic t_disabled(); // R2
        set_port(2, 0, 7'h05, 0, 2'b00, 1);
        run_vec(2, (24'h5 << 15) | 24'h77, "R2");
        chk("R2 disabled hit", 2, 16'(rsp_hit[2]), 16'd0);
        set_port(2, 1, 7'h05, 0, 2'b00, 1);
        run_vec(2, (24'h5 << 15) | 24'h77, "R2");
        chk("R2 enabled hit", 2, 16'(rsp_hit[2]), 16'd1);
    endtask

    task automatic t_range();    // R10
        set_port(0, 1, 7'h0D, 0, 2'b00, 0);
        run_vec(0, (24'hD << 15) | 24'h10, "R10");
        chk("R10 narrow above range", 0, 16'(rsp_hit[0]), 16'd0);
        set_port(0, 1, 7'h0D, 0, 2'b00, 1);
        run_vec(0, (24'hD << 15) | 24'h10, "R10");
        chk("R10 wide same addr", 0, 16'(rsp_hit[0]), 16'd1);
        set_port(0, 1, 7'h05, 0, 2'b00, 0);
        run_vec(0, (24'h5 << 15) | 24'h10, "R10");
        chk("R10 narrow in range", 0, 16'(rsp_hit[0]), 16'd1);
        set_port(0, 1, 7'h05, 0, 2'b00, 1);
        run_vec(0, 24'h40_0000 | (24'h5 << 15), "R10");
        chk("R10 wide bit 22", 0, 16'(rsp_hit[0]), 16'd0);
    endtask

    task automatic t_cfg_hold(); // R11
        set_port(0, 1, 7'h03, 0, 2'b00, 1);
        req_valid[0] = 1'b1;
        req_addr[23:0] = (24'h3 << 15) | 24'h5;
        cfg_base[6:0] = 7'h09;
        @(negedge clk);
        chk("R11 old base still used", 0, 16'(rsp_hit[0]), 16'd1);
        req_addr[23:0] = (24'h9 << 15) | 24'h5;
        @(negedge clk);
        chk("R11 new base not yet", 0, 16'(rsp_hit[0]), 16'd0);
        req_valid[0] = 1'b0;
        @(negedge clk);
        e_base[0] = 7'h09;
        chk("R11 idle valid", 0, 16'(rsp_valid[0]), 16'd0);
        run_vec(0, (24'h9 << 15) | 24'h5, "R11");
        chk("R11 new base after idle", 0, 16'(rsp_hit[0]), 16'd1);
    endtask

    task automatic t_hold();     // R3
        logic [15:0] keep;
        set_port(3, 1, 7'h02, 0, 2'b00, 1);
        run_vec(3, (24'h2 << 15) | 24'h6A5C, "R3");
        keep = rsp_index[63:48];
        @(negedge clk);
        chk("R3 idle valid", 3, 16'(rsp_valid[3]), 16'd0);
        chk("R3 idle hit", 3, 16'(rsp_hit[3]), 16'd0);
        chk("R3 idle index held", 3, rsp_index[63:48], keep);
    endtask

    task automatic t_rsvd();     // R12
        set_port(1, 1, 7'h06, 0, 2'b11, 1);
        run_vec(1, (24'h6 << 15) | 24'h2, "R12");
        chk("R12 reserved no hit", 1, 16'(rsp_hit[1]), 16'd0);
        run_vec(1, 24'h6 << 15, "R12");
        chk("R12 reserved no hit", 1, 16'(rsp_hit[1]), 16'd0);
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            e_en[p] = 0; e_base[p] = 0; e_s64[p] = 0; e_ilv[p] = 0; e_wide[p] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_none32();
        t_none64();
        t_two32();
        t_two64();
        t_four32();
        t_four64();
        t_ports();
        t_disabled();
        t_range();
        t_cfg_hold();
        t_hold();
        t_rsvd();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule